// File: doc/BRIEF.md
# Redundant SAR Sequencer with Shift Bits

This block is the digital sequencer of a differential successive-approximation converter whose capacitor array carries redundant bits and residue-shift bits. After the input has been sampled, a start pulse loads the start state into the per-bit P and N switch codes. A one-hot select then walks from the most significant bit to the least significant bit. For each bit the sequencer applies the trial code, lets a break-before-make dead time pass, enables the drivers for one decision cycle, and latches the comparator result into that bit. The comparator, the capacitor array, the timing source and weight reconstruction sit outside the block.

Redundant bits are ordinary trials that repeat a weight, so they need no special handling. Shift bits are chosen by a parameter bit-map. They start with both switches grounded, so they act as a pre-offset on the residue until their own trial, and after that they behave like any other bit. When dithering is enabled, the second, third and fourth shift bits in MSB-first order take a pseudo-random differential start value. Each one takes it at the moment the shift bit above it is decided. The random bits come from a 16-bit maximal-length LFSR that steps once per conversion. Dither bits appear in the output as plain decisions, so nothing needs to be subtracted afterwards.

Top module: `redundant_sar_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it, the select, both switch-code vectors, the decision vector, the driver enable and done are all zero.
- R2: A start pulse taken in idle with sample low sets, from the next cycle: the MSB to P=1,N=0; every non-shift bit below it to P=0,N=1; every shift bit to P=0,N=0. The decision vector is cleared at the same time.
- R3: During a conversion the select is one-hot and steps from bit NUM_BITS-1 down to bit 0. Each bit is held for DEAD_CYC+1 cycles. The select is zero when the block is idle.
- R4: While bit k is selected its code is P=1,N=0. At the end of its single driver-enabled cycle the comparator value d is latched: decisions[k]=d and the code becomes P=d,N=!d. Codes of bits already decided do not change again.
- R5: A shift bit, once reached, is tried and decided exactly as in R4.
- R6: The driver enable is low whenever sample is high, and low for the DEAD_CYC cycles that follow any change of switch code. It is high in exactly one cycle per trial, and that is the cycle in which the comparator is sampled.
- R7: A start pulse is ignored while sample is high or while a conversion is running. The select and the codes show no reaction to it.
- R8: With ditherEn high at start, the shift bits of MSB-first rank 2, 3 and 4 are loaded with P=r,N=!r at the edge where the next-higher shift bit is decided. Here r is LFSR bit 0, 1 or 2 respectively. The load is skipped when that bit is tried in the same edge.
- R9: The LFSR resets to 16'hACE1. It steps once at the last decision of every conversion, as q <= {q[14:0], q[15]^q[13]^q[12]^q[10]}.
- R10: With ditherEn low at start, every shift bit keeps P=0,N=0 until its own trial.
- R11: Done is high for exactly one cycle, in the cycle after bit 0 is decided. The decision vector then holds the full raw result, dither bits included, and keeps it until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sample | input | 1 | High while the array tracks the input; releases the drivers |
| start | input | 1 | One-cycle pulse that begins a conversion |
| ditherEn | input | 1 | Enables dither on shift bits, captured at start |
| cmpOut | input | 1 | Comparator decision, 1 keeps the tried bit |
| bitSel | output | NUM_BITS | One-hot select of the bit under trial |
| swP | output | NUM_BITS | P-side switch codes, 1 = reference, 0 = ground |
| swN | output | NUM_BITS | N-side switch codes, 1 = reference, 0 = ground |
| drvEn | output | 1 | Switch drivers enabled; comparator sampled in this cycle |
| decisions | output | NUM_BITS | Raw decision vector |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The properties assume that cmpOut is a settled function of the codes whenever drvEn is high. They also assume that reset is released synchronously, and that the shift-bit map keeps the MSB an ordinary bit. The stimulus meets these conditions in several ways. A behavioural residue model computes the comparator value from the switch codes the block drives. Inputs change only just after a clock edge. Sample is raised only between conversions. The conversions run with model-driven decisions and with decisions forced high and forced low, with dither on and off. Stray start pulses are placed where they must be ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef struct packed {
    logic startConv;
    logic decide;
    logic lastDecide;
  } seq_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DEAD   = 2'd1,
    ST_DECIDE = 2'd2
  } seq_state_t;

  localparam int LFSR_W          = 16;
  localparam int DITHER_RANK_LO  = 2;
  localparam int DITHER_RANK_HI  = 4;

  // MSB-first rank of a shift bit: count of map bits at index >= k
  function automatic int rsRank(input logic [63:0] map, input int k);
    int r;
    r = 0;
    for (int j = 0; j < 64; j++) begin
      if (j >= k && map[j]) r++;
    end
    return r;
  endfunction

  // nearest shift bit above k, or k itself when there is none
  function automatic int prevRs(input logic [63:0] map, input int k);
    int p;
    p = k;
    for (int j = 63; j >= 0; j--) begin
      if (j > k && map[j]) p = j;
    end
    return p;
  endfunction

endpackage

// File: rtl/sar_seq_control.sv
module sar_seq_control
  import sar_seq_pkg::*;
#(
  parameter int NUM_BITS = 12,
  parameter int DEAD_CYC = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                sample,
  output seq_strobe_t         strb,
  output logic [NUM_BITS-1:0] bitSel,
  output logic                drvEn,
  output logic                done
);

  localparam int CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYC - 1);
  localparam logic [NUM_BITS-1:0] SEL_MSB = {1'b1, {(NUM_BITS-1){1'b0}}};

  seq_state_t state;
  logic [CNT_W-1:0] deadCnt;

  always_comb begin
    strb.startConv  = (state == ST_IDLE) && start && !sample;
    strb.decide     = (state == ST_DECIDE) && !sample;
    strb.lastDecide = strb.decide && bitSel[0];
  end

  assign drvEn = (state == ST_DECIDE) && !sample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      deadCnt <= '0;
      bitSel  <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.lastDecide;
      unique case (state)
        ST_IDLE: begin
          if (strb.startConv) begin
            bitSel  <= SEL_MSB;
            deadCnt <= CNT_LOAD;
            state   <= ST_DEAD;
          end
        end
        ST_DEAD: begin
          if (deadCnt == '0) state <= ST_DECIDE;
          else deadCnt <= deadCnt - 1'b1;
        end
        ST_DECIDE: begin
          if (strb.decide) begin
            if (bitSel[0]) begin
              bitSel <= '0;
              state  <= ST_IDLE;
            end else begin
              bitSel  <= bitSel >> 1;
              deadCnt <= CNT_LOAD;
              state   <= ST_DEAD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sar_seq_datapath.sv
module sar_seq_datapath
  import sar_seq_pkg::*;
#(
  parameter int                    NUM_BITS  = 12,
  parameter logic [NUM_BITS-1:0]   RS_MAP    = '0,
  parameter logic [LFSR_W-1:0]     LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strb,
  input  logic [NUM_BITS-1:0] bitSel,
  input  logic                cmpOut,
  input  logic                ditherEn,
  output logic [NUM_BITS-1:0] swP,
  output logic [NUM_BITS-1:0] swN,
  output logic [NUM_BITS-1:0] decisions
);

  localparam logic [63:0] RS_WIDE = 64'(RS_MAP);

  logic [LFSR_W-1:0] lfsrQ;
  logic              ditherLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= LFSR_SEED;
    else if (strb.lastDecide)
      lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ditherLat <= 1'b0;
    else if (strb.startConv) ditherLat <= ditherEn;
  end

  for (genvar k = 0; k < NUM_BITS; k++) begin : g_bit
    localparam bit IS_MSB  = (k == NUM_BITS - 1);
    localparam bit IS_RS   = RS_MAP[k];
    localparam int RANK    = rsRank(RS_WIDE, k);
    localparam int PREV    = prevRs(RS_WIDE, k);
    localparam bit IS_DITH = IS_RS && (RANK >= DITHER_RANK_LO) &&
                             (RANK <= DITHER_RANK_HI) && (PREV != k) &&
                             (PREV < NUM_BITS);
    localparam int SLOT    = IS_DITH ? (RANK - DITHER_RANK_LO) : 0;

    logic trialNow;
    logic ditherNow;
    logic pQ, nQ, dQ;

    if (IS_MSB) begin : g_top
      assign trialNow = 1'b0;
    end else begin : g_low
      assign trialNow = strb.decide && bitSel[k+1];
    end

    if (IS_DITH) begin : g_dith
      assign ditherNow = strb.decide && ditherLat && bitSel[PREV];
    end else begin : g_plain
      assign ditherNow = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pQ <= 1'b0;
        nQ <= 1'b0;
        dQ <= 1'b0;
      end else if (strb.startConv) begin
        pQ <= IS_MSB;
        nQ <= !(IS_MSB || IS_RS);
        dQ <= 1'b0;
      end else if (strb.decide && bitSel[k]) begin
        pQ <= cmpOut;
        nQ <= !cmpOut;
        dQ <= cmpOut;
      end else if (trialNow) begin
        pQ <= 1'b1;
        nQ <= 1'b0;
      end else if (ditherNow) begin
        pQ <= lfsrQ[SLOT];
        nQ <= !lfsrQ[SLOT];
      end
    end

    assign swP[k]       = pQ;
    assign swN[k]       = nQ;
    assign decisions[k] = dQ;
  end

endmodule

// File: rtl/redundant_sar_sequencer.sv
module redundant_sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int                  NUM_BITS  = 12,
  parameter logic [NUM_BITS-1:0] RS_MAP    = 12'h14A,
  parameter int                  DEAD_CYC  = 1,
  parameter logic [15:0]         LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sample,
  input  logic                start,
  input  logic                ditherEn,
  input  logic                cmpOut,
  output logic [NUM_BITS-1:0] bitSel,
  output logic [NUM_BITS-1:0] swP,
  output logic [NUM_BITS-1:0] swN,
  output logic                drvEn,
  output logic [NUM_BITS-1:0] decisions,
  output logic                done
);

  seq_strobe_t strb;

  sar_seq_control #(
    .NUM_BITS(NUM_BITS),
    .DEAD_CYC(DEAD_CYC)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .sample(sample),
    .strb  (strb),
    .bitSel(bitSel),
    .drvEn (drvEn),
    .done  (done)
  );

  sar_seq_datapath #(
    .NUM_BITS (NUM_BITS),
    .RS_MAP   (RS_MAP),
    .LFSR_SEED(LFSR_SEED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bitSel   (bitSel),
    .cmpOut   (cmpOut),
    .ditherEn (ditherEn),
    .swP      (swP),
    .swN      (swN),
    .decisions(decisions)
  );

endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int NUM_BITS = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                sample,
  input logic                cmpOut,
  input logic [NUM_BITS-1:0] bitSel,
  input logic [NUM_BITS-1:0] swP,
  input logic [NUM_BITS-1:0] swN,
  input logic                drvEn,
  input logic [NUM_BITS-1:0] decisions,
  input logic                done
);

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bitSel));

  assert_sel_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && !bitSel[0]) |=> (bitSel == ($past(bitSel) >> 1)));

  assert_latch_decision_R4: assert property (@(posedge clk) disable iff (!rstN)
    drvEn |=> ((|(decisions & $past(bitSel))) == $past(cmpOut)));

  assert_sample_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    sample |-> !drvEn);

  assert_dead_after_change_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((swP != $past(swP)) || (swN != $past(swN))) |-> !drvEn);

  assert_drv_needs_sel_R6: assert property (@(posedge clk) disable iff (!rstN)
    drvEn |-> (bitSel != '0));

  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && bitSel[0]) |=> done);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind redundant_sar_sequencer sar_seq_checker #(.NUM_BITS(NUM_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sample   (sample),
  .cmpOut   (cmpOut),
  .bitSel   (bitSel),
  .swP      (swP),
  .swN      (swN),
  .drvEn    (drvEn),
  .decisions(decisions),
  .done     (done)
);

// File: tb/redundant_sar_sequencer_test.sv
`timescale 1ns/1ps
module redundant_sar_sequencer_test;

  localparam int          N    = 12;
  localparam logic [N-1:0] RS  = 12'h14A;
  localparam int          DEAD = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sample = 1'b0;
  logic start = 1'b0;
  logic ditherEn = 1'b0;
  logic cmpOut;
  logic [N-1:0] bitSel, swP, swN, decisions;
  logic drvEn, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int vin = 0;
  int forceMode = 0;   // 0 model, 1 force high, 2 force low
  int w [N];
  logic [15:0] bLfsr = 16'hACE1;

  always #2 clk = ~clk;

  redundant_sar_sequencer #(.NUM_BITS(N), .RS_MAP(RS), .DEAD_CYC(DEAD)) uut (
    .clk(clk), .rstN(rstN), .sample(sample), .start(start), .ditherEn(ditherEn),
    .cmpOut(cmpOut), .bitSel(bitSel), .swP(swP), .swN(swN), .drvEn(drvEn),
    .decisions(decisions), .done(done));

  function automatic logic modelCmp(input logic [N-1:0] p, input logic [N-1:0] n);
    int res;
    if (forceMode == 1) return 1'b1;
    if (forceMode == 2) return 1'b0;
    res = vin;
    for (int k = 0; k < N; k++) res -= w[k] * (int'(p[k]) - int'(n[k]));
    return (res >= 0);
  endfunction

  always_comb cmpOut = modelCmp(swP, swN);

  function automatic int rankOf(input int k);
    int r = 0;
    for (int j = k; j < N; j++) if (RS[j]) r++;
    return r;
  endfunction

  function automatic int nextLowerRs(input int k);
    int q = -1;
    for (int j = 0; j < k; j++) if (RS[j]) q = j;
    return q;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    chk(bitSel == '0, "R1 select", bitSel, 0);
    chk(swP == '0 && swN == '0, "R1 codes", {swP, swN}, 0);
    chk(decisions == '0, "R1 decisions", decisions, 0);
    chk(!drvEn && !done, "R1 drvEn/done", {drvEn, done}, 0);
  endtask

  task automatic runConv(input int v, input int fm, input bit dith, input bit midStart);
    logic [N-1:0] eP, eN, eD;
    logic d;
    vin = v;
    forceMode = fm;
    ditherEn = dith;
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int k = 0; k < N; k++) begin
      eP[k] = (k == N-1);
      eN[k] = !((k == N-1) || RS[k]);
    end
    eD = '0;
    chk(swP == eP && swN == eN, "R2 start codes", {swP, swN}, {eP, eN});
    chk(decisions == '0, "R2 cleared", decisions, 0);
    for (int k = N-1; k >= 0; k--) begin
      chk(bitSel == (N'(1) << k), "R3 select", bitSel, N'(1) << k);
      chk(swP == eP && swN == eN, "R4/R5/R8/R10 trial codes", {swP, swN}, {eP, eN});
      chk(!drvEn, "R6 dead time", drvEn, 0);
      if (midStart && k == N/2) start = 1'b1;
      for (int c = 1; c < DEAD; c++) begin
        tick();
        start = 1'b0;
        chk(!drvEn, "R6 dead time", drvEn, 0);
      end
      tick();
      start = 1'b0;
      chk(drvEn, "R6 decide cycle", drvEn, 1);
      chk(bitSel == (N'(1) << k), "R3/R7 select held", bitSel, N'(1) << k);
      d = modelCmp(eP, eN);
      eD[k] = d;
      eP[k] = d;
      eN[k] = !d;
      if (dith && RS[k]) begin
        int q;
        int rk;
        q = nextLowerRs(k);
        if (q >= 0) begin
          rk = rankOf(q);
          if (rk >= 2 && rk <= 4 && q != k-1) begin
            eP[q] = bLfsr[rk-2];
            eN[q] = !bLfsr[rk-2];
          end
        end
      end
      if (k > 0) begin
        eP[k-1] = 1'b1;
        eN[k-1] = 1'b0;
      end
      tick();
    end
    chk(done, "R11 done", done, 1);
    chk(decisions == eD, "R4/R11 decisions", decisions, eD);
    chk(swP == eP && swN == eN, "R4 final codes", {swP, swN}, {eP, eN});
    chk(bitSel == '0 && !drvEn, "R3 idle", {bitSel, drvEn}, 0);
    bLfsr = {bLfsr[14:0], bLfsr[15] ^ bLfsr[13] ^ bLfsr[12] ^ bLfsr[10]};
    tick();
    chk(!done, "R11 one-cycle done", done, 0);
    chk(decisions == eD, "R11 held result", decisions, eD);
  endtask

  task automatic testSampleAndStart();
    logic [N-1:0] p0, n0;
    p0 = swP;
    n0 = swN;
    sample = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(!drvEn, "R6 released in sample", drvEn, 0);
    end
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    chk(bitSel == '0, "R7 start ignored in sample", bitSel, 0);
    chk(swP == p0 && swN == n0, "R7 codes untouched", {swP, swN}, {p0, n0});
    sample = 1'b0;
    tick();
  endtask

  initial begin
    w[11] = 512; w[10] = 256; w[9] = 128; w[8] = 128; w[7] = 64; w[6] = 32;
    w[5]  = 32;  w[4]  = 16;  w[3] = 8;   w[2] = 8;   w[1] = 4;  w[0] = 2;
    repeat (3) tick();
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testSampleAndStart();
    runConv(300, 0, 1'b0, 1'b0);     // R10 plain conversion
    runConv(-450, 0, 1'b0, 1'b0);
    runConv(0, 1, 1'b0, 1'b0);       // all decisions high
    runConv(0, 2, 1'b0, 1'b0);       // all decisions low
    runConv(77, 0, 1'b0, 1'b1);      // R7 stray start mid conversion
    runConv(123, 0, 1'b1, 1'b0);     // R8 dither, R9 LFSR step
    runConv(-31, 0, 1'b1, 1'b0);
    runConv(0, 1, 1'b1, 1'b0);
    runConv(900, 0, 1'b1, 1'b1);
    testSampleAndStart();
    runConv(5, 0, 1'b1, 1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule